// File: doc/BRIEF.md
# Bipolar Zero-Substitution Line Encoder

This block turns a serial bit stream, one bit per clock-enable strobe, into the positive and negative rail bits of an alternate-mark-inversion line signal. Each one becomes a pulse whose polarity is the opposite of the previous pulse. Long runs of zeros are replaced with codes that carry a deliberate polarity violation. In the long-run mode, every four zeros are replaced with 000V or B00V. This is the rule used at the E3 rate. In the short-run mode, every three zeros are replaced with 00V or B0V. This is the rule used at the DS3 and STS-1 rates. In both modes the filler is chosen so that an odd number of pulses separates any two violations.

An encoder channel sits between the framer and the analog pulse shaper. It can also take data that is already split into two rails and pass it straight through. A maintenance input replaces the data with a continuous stream of marks. A select input chooses which edge of the clock samples the incoming data: the rising edge, or the falling edge half a cycle earlier.

Top module: `zs_line_encoder`

## Requirements
- R1: While `rst` is high, both rails are driven low on each rising edge. After reset, the last-pulse polarity reads as negative and the pulse parity reads as even. So the first mark comes out on `line_pos`, and a zero run that arrives before any mark starts with a B pulse.
- R2: With `single_rail`=1, each accepted one gives a pulse on exactly one rail, and each accepted zero that is not part of a substitution leaves both rails low. Successive non-violation pulses alternate between `line_pos` and `line_neg`. Both rails are never high together.
- R3: With `long_mode`=1, each run of four accepted zeros is replaced as follows. If the number of pulses since the previous violation (or since reset) is odd, the run becomes 000V. If it is even, the run becomes B00V.
- R4: With `long_mode`=0, each run of three accepted zeros is replaced with 00V when that pulse count is odd, and with B0V when it is even.
- R5: A B pulse takes the polarity opposite to the pulse before it. A V pulse repeats the polarity of the pulse before it.
- R6: In single-rail operation, the rail pair for the bit accepted on strobe k appears just after the rising edge of strobe k+4 in long-run mode, and strobe k+3 in short-run mode. Rails read low until the first bit has come through.
- R7: When `tx_en` is low, the rails and all coding state hold their values.
- R8: With `single_rail`=0, the sampled `tx_pos` and `tx_neg` are copied to `line_pos` and `line_neg` unchanged, on the rising edge of the same strobe that samples them. This includes the case where both are high.
- R9: With `single_rail`=1 and `all_ones`=1, every accepted bit is treated as a one whatever `tx_pos` carries. After the encoder latency, the output is an unbroken run of alternating marks.
- R10: With `fall_edge`=1, the input sampled for a strobe is the value present at the falling clock edge half a cycle before that strobe's rising edge. With `fall_edge`=0, it is the value present at the rising edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Bit strobe: one data bit is accepted on each rising edge where this is high |
| tx_pos | input | 1 | Single-rail data, or positive rail in dual-rail operation |
| tx_neg | input | 1 | Negative rail in dual-rail operation, ignored in single-rail |
| long_mode | input | 1 | 1 = four-zero substitution, 0 = three-zero substitution |
| single_rail | input | 1 | 1 = encode, 0 = dual-rail pass-through |
| all_ones | input | 1 | Replace the data with marks (single-rail) |
| fall_edge | input | 1 | 1 = sample inputs on the falling clock edge |
| line_pos | output | 1 | Registered positive-rail pulse bit |
| line_neg | output | 1 | Registered negative-rail pulse bit |

## Verification
The assertions assume that `long_mode` and `single_rail` change only while `rst` is high. A mode switch in mid-stream could leave the zero-run counter above the new run length, or leave the violation-gap parity out of step. The bench therefore sets every configuration input before it applies reset and holds it for the whole stretch of traffic. Idle cycles with `tx_en` low, and junk values on the edge that is not selected, are mixed in at random.

// File: rtl/zs_enc_pkg.sv
package zs_enc_pkg;
  // Symbol held in each slot of the substitution window
  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,  // no pulse
    SYM_MARK = 2'd1,  // data one, normal alternation
    SYM_BPOL = 2'd2,  // inserted balancing pulse, normal alternation
    SYM_VIOL = 2'd3   // violation pulse, repeats previous polarity
  } zs_sym_t;
endpackage

// File: rtl/zs_edge_capture.sv
module zs_edge_capture #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_sel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] fall_q;

  // One falling-edge stage per lane; the rising-edge path uses the pin itself
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    always_ff @(negedge clk) begin
      if (rst) fall_q[g] <= 1'b0;
      else     fall_q[g] <= din[g];
    end
    assign dout[g] = fall_sel ? fall_q[g] : din[g];
  end
endmodule

// File: rtl/zs_subst_window.sv
module zs_subst_window
  import zs_enc_pkg::*;
#(
  parameter int LONG_RUN  = 4,
  parameter int SHORT_RUN = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    strobe,
  input  logic    bit_in,
  input  logic    force_one,
  input  logic    long_mode,
  output zs_sym_t exit_sym
);
  localparam int DEPTH = LONG_RUN;
  localparam int CW    = (LONG_RUN > 2) ? $clog2(LONG_RUN) : 1;

  zs_sym_t        slot     [DEPTH];
  zs_sym_t        slot_nxt [DEPTH];
  logic [CW-1:0]  zrun;
  logic           par_odd;
  logic [CW-1:0]  run_m1;
  logic           entry_mark;
  logic           subst;
  logic           add_b;

  assign run_m1     = long_mode ? CW'(LONG_RUN - 1) : CW'(SHORT_RUN - 1);
  assign entry_mark = bit_in | force_one;
  assign subst      = !entry_mark && (zrun == run_m1);
  assign add_b      = subst && !par_odd;

  assign slot_nxt[0] = entry_mark ? SYM_MARK : (subst ? SYM_VIOL : SYM_ZERO);

  // Shift path; the oldest slot of the run becomes B when balance is needed
  for (genvar i = 1; i < DEPTH; i++) begin : g_slot
    assign slot_nxt[i] = (add_b && (run_m1 == CW'(i))) ? SYM_BPOL : slot[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= SYM_ZERO;
      zrun    <= '0;
      par_odd <= 1'b0;
    end else if (strobe) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= slot_nxt[i];
      if (entry_mark) begin
        zrun    <= '0;
        par_odd <= !par_odd;
      end else if (subst) begin
        zrun    <= '0;
        par_odd <= 1'b0;
      end else begin
        zrun    <= zrun + 1'b1;
      end
    end
  end

  // Symbol leaving the window on this strobe
  assign exit_sym = long_mode ? slot[DEPTH-1] : slot[SHORT_RUN-1];

  AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    zrun <= run_m1);  // R3
  AST_VIOL_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (slot[0] == SYM_VIOL) |-> (slot[1] == SYM_ZERO));  // R4
endmodule

// File: rtl/zs_rail_driver.sv
module zs_rail_driver
  import zs_enc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    strobe,
  input  logic    encode,
  input  zs_sym_t exit_sym,
  input  logic    byp_pos,
  input  logic    byp_neg,
  output logic    rail_pos,
  output logic    rail_neg
);
  logic last_pos;   // 1: previous pulse was positive
  logic pulse;
  logic pol_pos;
  logic gap_odd;    // pulses seen leaving since the last violation
  logic enc_q;

  assign pulse   = (exit_sym != SYM_ZERO);
  assign pol_pos = (exit_sym == SYM_VIOL) ? last_pos : !last_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_pos <= 1'b0;
      rail_neg <= 1'b0;
      last_pos <= 1'b0;
      enc_q    <= 1'b0;
    end else if (strobe) begin
      enc_q <= encode;
      if (encode) begin
        rail_pos <= pulse && pol_pos;
        rail_neg <= pulse && !pol_pos;
        if (pulse) last_pos <= pol_pos;
      end else begin
        rail_pos <= byp_pos;
        rail_neg <= byp_neg;
      end
    end
  end

  // Gap parity tracked at the exit, independently of the window's choice
  always_ff @(posedge clk) begin
    if (rst)                                   gap_odd <= 1'b0;
    else if (strobe && exit_sym == SYM_VIOL)   gap_odd <= 1'b0;
    else if (strobe && pulse)                  gap_odd <= !gap_odd;
  end

  AST_VIOL_ODD_GAP: assert property (@(posedge clk) disable iff (rst)
    (strobe && exit_sym == SYM_VIOL) |-> gap_odd);  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(rail_pos) && $stable(rail_neg)));  // R7
  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    enc_q |-> !(rail_pos && rail_neg));  // R2
endmodule

// File: rtl/zs_line_encoder.sv
module zs_line_encoder
  import zs_enc_pkg::*;
#(
  parameter int LONG_RUN  = 4,
  parameter int SHORT_RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic long_mode,
  input  logic single_rail,
  input  logic all_ones,
  input  logic fall_edge,
  output logic line_pos,
  output logic line_neg
);
  localparam int LANES = 2;

  logic [LANES-1:0] cap;
  zs_sym_t          exit_sym;

  zs_edge_capture #(.WIDTH(LANES)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .fall_sel (fall_edge),
    .din      ({tx_pos, tx_neg}),
    .dout     (cap)
  );

  zs_subst_window #(.LONG_RUN(LONG_RUN), .SHORT_RUN(SHORT_RUN)) u_win (
    .clk       (clk),
    .rst       (rst),
    .strobe    (tx_en),
    .bit_in    (cap[1]),
    .force_one (all_ones),
    .long_mode (long_mode),
    .exit_sym  (exit_sym)
  );

  zs_rail_driver u_drv (
    .clk      (clk),
    .rst      (rst),
    .strobe   (tx_en),
    .encode   (single_rail),
    .exit_sym (exit_sym),
    .byp_pos  (cap[1]),
    .byp_neg  (cap[0]),
    .rail_pos (line_pos),
    .rail_neg (line_neg)
  );
endmodule

// File: tb/zs_line_encoder_bench.sv
module zs_line_encoder_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst = 1'b1, tx_en = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
  logic long_mode = 1'b1, single_rail = 1'b1, all_ones = 1'b0, fall_edge = 1'b0;
  logic line_pos, line_neg;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit bp [400];
  bit bn [400];
  int sym [400];
  bit ep [400];
  bit en [400];

  zs_line_encoder u_zs_line_encoder (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .long_mode(long_mode), .single_rail(single_rail), .all_ones(all_ones),
    .fall_edge(fall_edge), .line_pos(line_pos), .line_neg(line_neg)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog: cycles=%0d expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Reference: substitution pass over the whole stream, then polarity pass
  task automatic build_expect(int len, int run, bit force1);
    int zr = 0;
    bit odd = 0;
    bit last = 0;
    bit pol;
    for (int i = 0; i < len; i++) begin
      if (force1 || bp[i]) begin
        sym[i] = 1; odd = !odd; zr = 0;
      end else begin
        sym[i] = 0; zr++;
        if (zr == run) begin
          sym[i] = 3;
          if (!odd) sym[i-run+1] = 2;
          odd = 0; zr = 0;
        end
      end
    end
    for (int i = 0; i < len; i++) begin
      if (sym[i] == 0) begin
        ep[i] = 0; en[i] = 0;
      end else begin
        pol = (sym[i] == 3) ? last : !last;
        ep[i] = pol; en[i] = !pol; last = pol;
      end
    end
  endtask

  task automatic check(string tag, bit p, bit n);
    n_cmp++;
    if (line_pos !== p || line_neg !== n) begin
      n_bad++;
      $display("FAIL %s: rails=%b%b expected=%b%b", tag, line_pos, line_neg, p, n);
    end
  endtask

  // One clock: value a held over the falling edge, value b over the rising edge
  task automatic step(bit e, bit ap, bit an, bit bpv, bit bnv);
    #1;
    tx_en = e; tx_pos = ap; tx_neg = an;
    @(negedge clk); #3;
    tx_pos = bpv; tx_neg = bnv;
    @(posedge clk); #2;
  endtask

  task automatic run_seg(string tag, bit lng, bit sr, bit ao, bit fe,
                         int ndir, int len, int dens);
    int run;
    bit cp, cn, jp, jn;
    long_mode = lng; single_rail = sr; all_ones = ao; fall_edge = fe;
    tx_en = 0; rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #1;
    check("R1 reset", 0, 0);
    for (int i = ndir; i < len; i++) begin
      bp[i] = ($urandom % 100) < dens;
      bn[i] = ($urandom % 2) == 0;
    end
    run = lng ? 4 : 3;
    if (sr) build_expect(len, run, ao);
    cp = 0; cn = 0;
    for (int k = 0; k < len; k++) begin
      if ($urandom % 5 == 0) begin
        step(0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
        check("R7 idle hold", cp, cn);
      end
      jp = $urandom % 2; jn = $urandom % 2;
      if (fe) step(1, bp[k], bn[k], jp, jn);
      else    step(1, jp, jn, bp[k], bn[k]);
      if (sr) begin
        cp = (k >= run) ? ep[k-run] : 1'b0;
        cn = (k >= run) ? en[k-run] : 1'b0;
      end else begin
        cp = bp[k]; cn = bn[k];
      end
      check(tag, cp, cn);
    end
  endtask

  task automatic load(string s);
    for (int i = 0; i < s.len(); i++) bp[i] = (s[i] == "1");
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(posedge clk);
    // R1 R3 R5 R6: cold-start B00V, then 000V after one mark, then mixed
    load("000010000110000000010001");
    run_seg("R1,R3,R5,R6 long-run", 1, 1, 0, 0, 24, 150, 30);
    // R4 R5 R6: three-zero rule
    load("000100011000000100 1");
    run_seg("R4,R5,R6 short-run", 0, 1, 0, 0, 18, 150, 30);
    // R2: dense marks, alternation
    run_seg("R2 alternation", 1, 1, 0, 0, 0, 100, 70);
    // R9: data zeros replaced by marks
    for (int i = 0; i < 60; i++) bp[i] = 0;
    run_seg("R9 all-ones", 1, 1, 1, 0, 60, 60, 0);
    // R8: dual-rail pass-through, including both rails high
    run_seg("R8 dual-rail", 1, 0, 0, 0, 0, 80, 50);
    // R10: falling-edge sampling, both modes
    run_seg("R10 fall-edge long", 1, 1, 0, 1, 0, 100, 30);
    run_seg("R10 fall-edge dual", 0, 0, 0, 1, 0, 60, 50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule